// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller with Row Refresh

This block connects a simple synchronous request port to a DRAM-style cell array whose address pins are shared between row and column. Each request is split into a row phase (row address plus row strobe) and a column phase (column address plus column strobe). After an access, the row is left open. A later request to the same row skips the row phase and only presents a new column. A request to a different row first closes the open row, waits out a precharge time, and then opens the new row.

An interval timer asks for refresh often enough that every row is restored within a retention window. The window is a parameter that stands in for a few milliseconds of real time. Each refresh is a row-only cycle on the next row in a wrapping sequence, so a whole row is restored at a time. A refresh request takes precedence over new user requests, but it never breaks into an access that has already begun.

Reading a cell destroys its charge. The array keeps the sensed row in its sense buffer, and the buffer is written back only when the row strobe drops. For this reason, every row the controller opens is closed cleanly through a precharge.

Top module: `pagedram_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, `mem_ras`, `mem_cas` and `req_ready` are low.
- R2: The upper ROW_W bits of `req_addr` select the row and the lower COL_W bits select the column. The row value is on `mem_addr` when `mem_ras` rises, the zero-extended column is on `mem_addr` while `mem_cas` is high, and `mem_cas` is high for exactly one cycle per access.
- R3: Once `mem_ras` falls, it stays low for at least T_RP cycles before it rises again.
- R4: `mem_cas` is asserted only while `mem_ras` is high, and no earlier than T_RCD cycles after `mem_ras` rose.
- R5: `req_ready` is a one-cycle pulse. For a read, `req_rdata` holds the word the array presents T_CL cycles after the column strobe. A write completes when the column strobe has been taken. Counting clock edges from the first edge that sees `req_valid`, an access to a closed row takes T_RCD+T_CL+2 edges for a read and T_RCD+2 for a write.
- R6: An access to the open row issues no row strobe activity and takes T_CL+2 edges for a read or 2 for a write. An access to a different row first lowers `mem_ras`, which adds T_RP edges to the closed-row figures.
- R7: A pending refresh is served before any waiting request. Under back-to-back traffic, the number of refreshes matches elapsed cycles divided by the refresh interval, within one. Between a read column strobe and its `req_ready`, `mem_ras` stays high.
- R8: A refresh is a row-only cycle: no column strobe, `mem_ras` held high for exactly T_RAS cycles. It is preceded by a close of any open row. Refreshed rows go in ascending order and wrap from the last row to row 0.
- R9: The refresh interval is RETAIN_CYC/(2·rows) cycles, so that every row is restored within RETAIN_CYC cycles with or without traffic.
- R10: Stored data survives repeated reads and row changes. Every read returns the last value written to that address, or the initial content if the address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address: row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with `req_ready` |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address to the array |
| mem_ras | output | 1 | Row strobe, active high; high keeps the row open |
| mem_cas | output | 1 | Column strobe, active high |
| mem_we | output | 1 | Write enable, qualified by `mem_cas` |
| mem_din | output | DATA_W | Data into the array |
| mem_dout | input | DATA_W | Data out of the array |

## Verification
An open-row flag that disagrees with the strobe pins shows up within one access in two ways. If the controller wrongly believes a row is open, it strobes a column on the wrong row and a read returns the wrong word. If it wrongly believes the row is closed, the bench sees extra row activity and a latency off by T_RCD or T_RP. A wrong wait count appears on the next read as poisoned data or as a timing violation seen by the array model. A stalled or misordered refresh row counter is caught once a row ages beyond the retention window, when the model corrupts that row and the next full sweep reads back bad words.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_RDWAIT,
        ST_RACT,
        ST_RPRE
    } dctl_state_e;

    typedef enum logic {
        CAUSE_ACCESS,
        CAUSE_REFRESH
    } pre_cause_e;

    function automatic int dctl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dctl_ref_timer.sv
module dctl_ref_timer #(
    parameter int INTERVAL = 100,
    parameter int ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] next_row
);
    localparam int TICK_W = $clog2(INTERVAL + 1);

    logic [TICK_W-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick     <= '0;
            pending  <= 1'b0;
            next_row <= '0;
        end else begin
            if (ack) begin
                pending  <= 1'b0;
                next_row <= next_row + 1'b1;
            end
            if (tick == TICK_W'(INTERVAL - 1)) begin
                tick    <= '0;
                pending <= 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dctl_page_track.sv
module dctl_page_track #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             is_open,
    output logic             hit
);
    logic [ROW_W-1:0] held_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            held_row <= '0;
        end else if (close) begin
            is_open <= 1'b0;
        end else if (open_set) begin
            is_open  <= 1'b1;
            held_row <= set_row;
        end
    end

    assign hit = is_open && (held_row == req_row);

endmodule

// File: rtl/dctl_seq.sv
module dctl_seq
    import dctl_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 16,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 3,
    parameter int T_CL   = 2,
    parameter int T_RAS  = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                req_valid,
    input  logic                                req_write,
    input  logic [ROW_W-1:0]                    req_row,
    input  logic [COL_W-1:0]                    req_col,
    input  logic [DATA_W-1:0]                   req_wdata,
    input  logic                                is_open,
    input  logic                                hit,
    input  logic                                ref_pend,
    input  logic [ROW_W-1:0]                    ref_row,
    output logic                                ref_ack,
    output logic                                open_set,
    output logic                                close,
    output logic [ROW_W-1:0]                    cur_row,
    output logic                                req_ready,
    output logic [DATA_W-1:0]                   req_rdata,
    output logic [dctl_max(ROW_W,COL_W)-1:0]    mem_addr,
    output logic                                mem_ras,
    output logic                                mem_cas,
    output logic                                mem_we,
    output logic [DATA_W-1:0]                   mem_din,
    input  logic [DATA_W-1:0]                   mem_dout
);
    localparam int MA_W  = dctl_max(ROW_W, COL_W);
    localparam int LONG  = dctl_max(dctl_max(T_RP, T_RCD), dctl_max(T_CL, T_RAS));
    localparam int CNT_W = $clog2(LONG + 1);

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } access_t;

    dctl_state_e       st;
    pre_cause_e        cause;
    access_t           cur;
    logic [CNT_W-1:0]  cnt;

    assign ref_ack = (st == ST_RPRE) && (cnt == '0);
    assign cur_row = cur.row;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cause     <= CAUSE_ACCESS;
            cur       <= '0;
            cnt       <= '0;
            mem_ras   <= 1'b0;
            mem_cas   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_din   <= '0;
            req_ready <= 1'b0;
            req_rdata <= '0;
            open_set  <= 1'b0;
            close     <= 1'b0;
        end else begin
            req_ready <= 1'b0;
            mem_cas   <= 1'b0;
            mem_we    <= 1'b0;
            open_set  <= 1'b0;
            close     <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (ref_pend) begin
                        if (is_open) begin
                            mem_ras <= 1'b0;
                            close   <= 1'b1;
                            cause   <= CAUSE_REFRESH;
                            cnt     <= CNT_W'(T_RP - 1);
                            st      <= ST_PRE;
                        end else begin
                            mem_ras  <= 1'b1;
                            mem_addr <= MA_W'(ref_row);
                            cnt      <= CNT_W'(T_RAS - 1);
                            st       <= ST_RACT;
                        end
                    end else if (req_valid) begin
                        cur <= '{wr: req_write, row: req_row, col: req_col, wdata: req_wdata};
                        if (hit) begin
                            mem_cas  <= 1'b1;
                            mem_we   <= req_write;
                            mem_addr <= MA_W'(req_col);
                            mem_din  <= req_wdata;
                            st       <= ST_COL;
                        end else if (is_open) begin
                            mem_ras <= 1'b0;
                            close   <= 1'b1;
                            cause   <= CAUSE_ACCESS;
                            cnt     <= CNT_W'(T_RP - 1);
                            st      <= ST_PRE;
                        end else begin
                            mem_ras  <= 1'b1;
                            mem_addr <= MA_W'(req_row);
                            open_set <= 1'b1;
                            cnt      <= CNT_W'(T_RCD - 1);
                            st       <= ST_ACT;
                        end
                    end
                end
                ST_PRE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (cause == CAUSE_REFRESH) begin
                        mem_ras  <= 1'b1;
                        mem_addr <= MA_W'(ref_row);
                        cnt      <= CNT_W'(T_RAS - 1);
                        st       <= ST_RACT;
                    end else begin
                        mem_ras  <= 1'b1;
                        mem_addr <= MA_W'(cur.row);
                        open_set <= 1'b1;
                        cnt      <= CNT_W'(T_RCD - 1);
                        st       <= ST_ACT;
                    end
                end
                ST_ACT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        mem_cas  <= 1'b1;
                        mem_we   <= cur.wr;
                        mem_addr <= MA_W'(cur.col);
                        mem_din  <= cur.wdata;
                        st       <= ST_COL;
                    end
                end
                ST_COL: begin
                    if (cur.wr) begin
                        req_ready <= 1'b1;
                        st        <= ST_IDLE;
                    end else begin
                        cnt <= CNT_W'(T_CL - 1);
                        st  <= ST_RDWAIT;
                    end
                end
                ST_RDWAIT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        req_rdata <= mem_dout;
                        req_ready <= 1'b1;
                        st        <= ST_IDLE;
                    end
                end
                ST_RACT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        mem_ras <= 1'b0;
                        cnt     <= CNT_W'(T_RP - 1);
                        st      <= ST_RPRE;
                    end
                end
                ST_RPRE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pagedram_ctrl.sv
module pagedram_ctrl
    import dctl_pkg::*;
#(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 8,
    parameter int DATA_W     = 16,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 3,
    parameter int T_CL       = 2,
    parameter int T_RAS      = 4,
    parameter int RETAIN_CYC = 400000
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             req_valid,
    input  logic                             req_write,
    input  logic [ROW_W+COL_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]                req_wdata,
    output logic                             req_ready,
    output logic [DATA_W-1:0]                req_rdata,
    output logic [dctl_max(ROW_W,COL_W)-1:0] mem_addr,
    output logic                             mem_ras,
    output logic                             mem_cas,
    output logic                             mem_we,
    output logic [DATA_W-1:0]                mem_din,
    input  logic [DATA_W-1:0]                mem_dout
);
    localparam int ROWS     = 1 << ROW_W;
    localparam int INTERVAL = RETAIN_CYC / (2 * ROWS);
    localparam int ADDR_W   = ROW_W + COL_W;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             ref_pend;
    logic             ref_ack;
    logic [ROW_W-1:0] ref_row;
    logic             is_open;
    logic             hit;
    logic             open_set;
    logic             close;
    logic [ROW_W-1:0] cur_row;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    dctl_ref_timer #(.INTERVAL(INTERVAL), .ROW_W(ROW_W)) u_timer (
        .clk(clk), .rst(rst), .ack(ref_ack),
        .pending(ref_pend), .next_row(ref_row)
    );

    dctl_page_track #(.ROW_W(ROW_W)) u_page (
        .clk(clk), .rst(rst), .open_set(open_set), .close(close),
        .set_row(cur_row), .req_row(req_row),
        .is_open(is_open), .hit(hit)
    );

    dctl_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL), .T_RAS(T_RAS)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .is_open(is_open), .hit(hit),
        .ref_pend(ref_pend), .ref_row(ref_row), .ref_ack(ref_ack),
        .open_set(open_set), .close(close), .cur_row(cur_row),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_addr(mem_addr), .mem_ras(mem_ras), .mem_cas(mem_cas),
        .mem_we(mem_we), .mem_din(mem_din), .mem_dout(mem_dout)
    );

endmodule

// File: rtl/dctl_checker.sv
module dctl_checker #(
    parameter int T_RP  = 3,
    parameter int T_RCD = 3
) (
    input logic clk,
    input logic rst,
    input logic mem_ras,
    input logic mem_cas,
    input logic mem_we,
    input logic req_ready
);
    localparam int LIM   = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int CNT_W = $clog2(LIM + 1) + 1;

    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic             rd_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= CNT_W'(LIM);
            high_cnt <= '0;
            rd_busy  <= 1'b0;
        end else begin
            if (mem_ras) begin
                low_cnt <= '0;
                if (high_cnt < CNT_W'(LIM)) high_cnt <= high_cnt + 1'b1;
            end else begin
                high_cnt <= '0;
                if (low_cnt < CNT_W'(LIM)) low_cnt <= low_cnt + 1'b1;
            end
            if (mem_cas && !mem_we) rd_busy <= 1'b1;
            else if (req_ready)     rd_busy <= 1'b0;
        end
    end

    AST_PRECHARGE_TIME: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ras) |-> (low_cnt >= CNT_W'(T_RP))); // R3

    AST_COL_INSIDE_ROW: assert property (@(posedge clk) disable iff (rst)
        mem_cas |-> mem_ras); // R4

    AST_ROW_TO_COL_TIME: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cas) |-> (high_cnt >= CNT_W'(T_RCD))); // R4

    AST_COL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_cas |=> !mem_cas); // R2

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready); // R5

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> mem_ras); // R7

endmodule

bind pagedram_ctrl dctl_checker #(.T_RP(T_RP), .T_RCD(T_RCD)) u_chk (
    .clk(clk), .rst(rst), .mem_ras(mem_ras), .mem_cas(mem_cas),
    .mem_we(mem_we), .req_ready(req_ready)
);

// File: tb/sim_pagedram_ctrl.sv
`timescale 1ns/1ps
module sim_pagedram_ctrl;
    localparam int RW     = 3;
    localparam int CW     = 3;
    localparam int DW     = 8;
    localparam int NR     = 1 << RW;
    localparam int NC     = 1 << CW;
    localparam int NA     = NR * NC;
    localparam int TRP    = 2;
    localparam int TRCD   = 2;
    localparam int TCL    = 2;
    localparam int TRAS   = 3;
    localparam int RETAIN = 1600;
    localparam int IVL    = RETAIN / (2 * NR);
    localparam logic [DW-1:0] POISON_CELL = 8'hEE;
    localparam logic [DW-1:0] POISON_OUT  = 8'h5A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [RW+CW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] req_rdata;
    logic [CW-1:0] mem_addr;
    logic          mem_ras, mem_cas, mem_we;
    logic [DW-1:0] mem_din, mem_dout;

    always #2.5 clk = ~clk;

    pagedram_ctrl #(
        .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RP(TRP), .T_RCD(TRCD),
        .T_CL(TCL), .T_RAS(TRAS), .RETAIN_CYC(RETAIN)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .mem_addr(mem_addr), .mem_ras(mem_ras),
        .mem_cas(mem_cas), .mem_we(mem_we), .mem_din(mem_din), .mem_dout(mem_dout)
    );

    // ---------------- behavioural array model ----------------
    logic [DW-1:0] cells  [NR][NC];
    logic [DW-1:0] rowbuf [NC];
    int            last_restore [NR];
    logic          aged [NR];
    logic          m_open = 1'b0;
    logic [RW-1:0] m_row = '0;
    logic [CW-1:0] m_col = '0;
    logic [CW-1:0] last_cas_col = '0;
    logic          rd_armed = 1'b0;
    int            cl_cnt = 0;
    logic          saw_cas = 1'b0;
    int            cyc = 0;
    int            rise_cyc = -100;
    int            fall_cyc = -100;
    int            viol_rp = 0, viol_rcd = 0, viol_cas = 0, viol_ret = 0;
    int            viol_ras = 0, ref_seq_err = 0, ref_count = 0, row_opens = 0;
    int            last_ref_row = 0;

    assign mem_dout = (rd_armed && cl_cnt == 0 && m_open) ? rowbuf[m_col] : POISON_OUT;

    function automatic logic [DW-1:0] init_val(input int r, input int c);
        return DW'((r * 16 + c) ^ 8'h30);
    endfunction

    initial begin
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < NC; c++) cells[r][c] = init_val(r, c);
            last_restore[r] = 0;
            aged[r] = 1'b0;
        end
        for (int c = 0; c < NC; c++) rowbuf[c] = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int r = 0; r < NR; r++) last_restore[r] <= cyc;
        end else begin
            if (mem_ras && !m_open) begin
                if (cyc - fall_cyc < TRP) viol_rp <= viol_rp + 1;
                m_open   <= 1'b1;
                m_row    <= mem_addr[RW-1:0];
                rise_cyc <= cyc;
                saw_cas  <= 1'b0;
                rd_armed <= 1'b0;
                row_opens <= row_opens + 1;
                for (int c = 0; c < NC; c++) begin
                    rowbuf[c] <= cells[mem_addr[RW-1:0]][c];
                    cells[mem_addr[RW-1:0]][c] <= POISON_CELL;
                end
            end else if (!mem_ras && m_open) begin
                m_open   <= 1'b0;
                fall_cyc <= cyc;
                rd_armed <= 1'b0;
                last_restore[m_row] <= cyc;
                for (int c = 0; c < NC; c++) cells[m_row][c] <= rowbuf[c];
                if (!saw_cas) begin
                    ref_count <= ref_count + 1;
                    if (cyc - rise_cyc != TRAS) viol_ras <= viol_ras + 1;
                    if (ref_count > 0 && int'(m_row) != (last_ref_row + 1) % NR)
                        ref_seq_err <= ref_seq_err + 1;
                    last_ref_row <= int'(m_row);
                end
            end
            if (mem_cas) begin
                if (!m_open || !mem_ras) viol_cas <= viol_cas + 1;
                if (cyc - rise_cyc < TRCD) viol_rcd <= viol_rcd + 1;
                saw_cas      <= 1'b1;
                last_cas_col <= mem_addr[CW-1:0];
                if (mem_we) begin
                    rowbuf[mem_addr[CW-1:0]] <= mem_din;
                end else begin
                    m_col    <= mem_addr[CW-1:0];
                    cl_cnt   <= TCL - 1;
                    rd_armed <= 1'b1;
                end
            end else if (cl_cnt > 0) begin
                cl_cnt <= cl_cnt - 1;
            end
            for (int r = 0; r < NR; r++) begin
                if (!(m_open && m_row == RW'(r)) && (cyc - last_restore[r] > RETAIN) && !aged[r]) begin
                    aged[r]  <= 1'b1;
                    viol_ret <= viol_ret + 1;
                    for (int c = 0; c < NC; c++) cells[r][c] <= POISON_CELL;
                end
            end
        end
    end

    // ---------------- checking ----------------
    int   n_chk = 0;
    int   n_bad = 0;
    logic done  = 1'b0;
    logic [DW-1:0] shadow [NA];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic access(input logic wr, input int addr, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = (RW + CW)'(addr);
        req_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ready && lat < 300);
        rd = req_rdata;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic quiet_after_refresh();
        int rc;
        rc = ref_count;
        while (ref_count == rc) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic sweep_read(input string req);
        logic [DW-1:0] rd;
        int lat;
        for (int a = 0; a < NA; a++) begin
            access(1'b0, a, '0, rd, lat);
            chk(rd == shadow[a], req, rd, shadow[a]);
        end
    endtask

    initial begin
        logic [DW-1:0] rd;
        int lat, opens0, c0, r0;
        for (int a = 0; a < NA; a++) shadow[a] = init_val(a / NC, a % NC);

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!mem_ras && !mem_cas && !req_ready, "R1 in reset", {mem_ras, mem_cas, req_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_ras && !mem_cas && !req_ready, "R1 after reset", {mem_ras, mem_cas, req_ready}, 0);

        // R2/R5/R6: latencies and addressing, in a refresh-free window
        quiet_after_refresh();
        opens0 = row_opens;
        access(1'b1, 2 * NC + 1, 8'hC3, rd, lat);
        shadow[2 * NC + 1] = 8'hC3;
        chk(lat == TRCD + 2, "R5 closed-row write latency", lat, TRCD + 2);
        chk(m_row == 3'd2 && last_cas_col == 3'd1, "R2 row/col split", {m_row, last_cas_col}, 8'h11);
        access(1'b0, 2 * NC + 1, '0, rd, lat);
        chk(lat == TCL + 2, "R6 open-row read latency", lat, TCL + 2);
        chk(rd == 8'hC3, "R5 read-after-write data", rd, 8'hC3);
        access(1'b1, 2 * NC + 5, 8'h3C, rd, lat);
        shadow[2 * NC + 5] = 8'h3C;
        chk(lat == 2, "R6 open-row write latency", lat, 2);
        chk(row_opens == opens0 + 1, "R6 no row strobe on hits", row_opens - opens0, 1);
        access(1'b0, 5 * NC + 3, '0, rd, lat);
        chk(lat == TRP + TRCD + TCL + 2, "R6 row-change read latency", lat, TRP + TRCD + TCL + 2);
        chk(rd == init_val(5, 3), "R10 untouched word after row change", rd, init_val(5, 3));
        quiet_after_refresh();
        access(1'b0, 0, '0, rd, lat);
        chk(lat == TRCD + TCL + 2, "R5 closed-row read latency", lat, TRCD + TCL + 2);
        chk(rd == shadow[0], "R10 initial content", rd, shadow[0]);

        // R7/R10: back-to-back row-sequential writes then reads
        c0 = cyc; r0 = ref_count;
        for (int a = 0; a < NA; a++) begin
            shadow[a] = DW'(a * 5 + 8'h11);
            access(1'b1, a, shadow[a], rd, lat);
        end
        sweep_read("R10 sequential sweep");
        sweep_read("R10 re-read after destructive reads");

        // column-major order: every access changes row
        for (int c = 0; c < NC; c++) begin
            for (int r = 0; r < NR; r++) begin
                shadow[r * NC + c] = DW'(r * 37 + c * 11 + 8'h5);
                access(1'b1, r * NC + c, shadow[r * NC + c], rd, lat);
            end
        end
        for (int c = NC - 1; c >= 0; c--) begin
            for (int r = NR - 1; r >= 0; r--) begin
                access(1'b0, r * NC + c, '0, rd, lat);
                chk(rd == shadow[r * NC + c], "R10 row-thrash read", rd, shadow[r * NC + c]);
            end
        end
        lat = (cyc - c0) / IVL;
        chk((ref_count - r0) >= lat - 1 && (ref_count - r0) <= lat + 1,
            "R7 refresh count under traffic", ref_count - r0, lat);

        // R9: idle longer than the retention window, data must survive
        repeat (2 * RETAIN) @(negedge clk);
        sweep_read("R9 data after idle retention window");

        chk(viol_rp == 0,     "R3 precharge violations", viol_rp, 0);
        chk(viol_rcd == 0,    "R4 row-to-column violations", viol_rcd, 0);
        chk(viol_cas == 0,    "R4 column strobe outside row", viol_cas, 0);
        chk(viol_ras == 0,    "R8 refresh row-active width", viol_ras, 0);
        chk(ref_seq_err == 0, "R8 refresh row order", ref_seq_err, 0);
        chk(ref_count >= NR + 1, "R8 refresh wrapped all rows", ref_count, NR + 1);
        chk(viol_ret == 0,    "R9 retention violations", viol_ret, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule